// File: doc/BRIEF.md
# Programmable Wake-Up Timer

A 32-bit timer that keeps counting while the processor core clock is gated. It is advanced by one of four clock sources. Each source reaches the block as a synchronous tick-enable input, and a two-bit field picks which one is used. The chosen ticks pass through a prescaler that divides by 1, 16, 256 or 32768. Each prescaled step moves the count one place up or down. When the count passes its terminal value, the block raises a sticky interrupt. In periodic mode it then reloads from a load register; in free-running mode the count simply wraps.

Software reaches the block over a word-wide register bus with a two-bit word index, a write strobe and combinational read data. Any write to the clear location does three things: it reloads the count at once, clears the interrupt and restarts the prescaler. A separate request input captures the live count into an output register, but only while the interrupt-enable input is high. A two-bit format field selects plain binary or an hours:minutes:seconds:hundredths layout. It is stored and driven out to the time-of-day counter, which lives in a separate block.

Top module: `wake_timer`

## Requirements
- R1: Each prescaled step adds one to the count when control bit 6 is set, and subtracts one when it is clear. Down counting is the reset default.
- R2: Control bits 3:0 set the prescale ratio. 0100 divides by 16, 1000 by 256 and 1111 by 32768. 0000 and every other code divide by 1, so a step occurs on every Nth selected tick.
- R3: Control bits 10:9 choose the tick input that feeds the prescaler: tick_src[0] for 00, tick_src[1] for 01, tick_src[2] for 10 and tick_src[3] for 11. Ticks on the other inputs have no effect.
- R4: Control bit 7 enables the timer. While it is clear, the count holds and the prescaler phase returns to zero.
- R5: On a step past the terminal value (0 when counting down, all ones when counting up), periodic mode (control bit 8 set) loads the load register. Free-running mode wraps to all ones when counting down or to zero when counting up.
- R6: A write of any data to word 2 loads the count from the load register on that edge, clears the interrupt and zeroes the prescaler phase. It takes priority over a step in the same cycle.
- R7: The irq output sets on the edge of a terminal wrap and stays set until word 2 is written.
- R8: When cap_req and irq_en are both high, cap_val takes the current count on the next edge; otherwise cap_val holds.
- R9: Word 0 is the load register (read/write), word 1 is the count (read only, writes ignored), word 2 reads zero, and word 3 is control. Reset clears everything. Control bits 31:11 read zero, and control bits 5:4 drive fmt_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 4 | Tick enables from the four clock sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq_en | input | 1 | Interrupt enable; gates capture |
| cap_req | input | 1 | Capture request |
| cap_val | output | 32 | Captured count |
| irq | output | 1 | Sticky wrap interrupt |
| fmt_sel | output | 2 | Counter format for the time-of-day block |

## Verification
Every cycle, the assertions check four behaviours:
- the reload and interrupt clearing that a clear write causes;
- that the count holds with no step;
- single-step down counting;
- the stickiness and cause of the interrupt, and the capture gate.

Only the bench's scenarios can show the exact prescale ratios for each code, the selection of each tick source, the reload against the wrap in each direction and mode, and the control masking on readback. They do so by comparing every output against a behavioural model under randomized ticks, capture requests and interrupt enables.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_PW = 15;
  localparam int WT_CW = 11;

  typedef enum logic [1:0] {
    A_LOAD  = 2'd0,
    A_VALUE = 2'd1,
    A_CLEAR = 2'd2,
    A_CTRL  = 2'd3
  } wt_addr_e;

  typedef struct packed {
    logic [1:0] src;
    logic       periodic;
    logic       enable;
    logic       up;
    logic [1:0] fmt;
    logic [3:0] pre;
  } wt_ctl_t;

  function automatic logic [WT_PW-1:0] ratio_last(input logic [3:0] pre);
    case (pre)
      4'b0100: ratio_last = WT_PW'(15);
      4'b1000: ratio_last = WT_PW'(255);
      4'b1111: ratio_last = WT_PW'(32767);
      default: ratio_last = '0;
    endcase
  endfunction
endpackage

// File: rtl/wt_regs.sv
module wt_regs #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   cnt,
  output logic [DW-1:0]   load_q,
  output wt_pkg::wt_ctl_t ctl_q,
  output logic            clr,
  output logic [DW-1:0]   rdata
);
  import wt_pkg::*;
  localparam int PADW = DW - WT_CW;

  logic [DW-1:0] load_d;
  wt_ctl_t       ctl_d;
  logic          load_we, ctl_we;

  always_comb begin
    load_we = wr_en && (addr == A_LOAD);
    ctl_we  = wr_en && (addr == A_CTRL);
    clr     = wr_en && (addr == A_CLEAR);
    load_d  = load_we ? wdata : load_q;
    ctl_d   = ctl_we ? wt_ctl_t'(wdata[WT_CW-1:0]) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctl_q  <= '0;
    end else begin
      load_q <= load_d;
      ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    case (addr)
      A_LOAD:  rdata = load_q;
      A_VALUE: rdata = cnt;
      A_CTRL:  rdata = {{PADW{1'b0}}, ctl_q};
      default: rdata = '0;
    endcase
  end

  p_value_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_VALUE) |=> ($stable(load_q) && $stable(ctl_q)));
endmodule

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  wt_pkg::wt_ctl_t ctl,
  input  logic            clr,
  output logic            step
);
  import wt_pkg::*;
  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0]  hit;
  logic             tick, at_last;
  logic [WT_PW-1:0] last, pcnt_q, pcnt_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = tick_src[i] && (ctl.src == SW'(i));
  end

  always_comb begin
    tick    = |hit;
    last    = ratio_last(ctl.pre);
    at_last = (pcnt_q >= last);
    step    = ctl.enable && tick && at_last;
    pcnt_d  = pcnt_q;
    if (clr || !ctl.enable) pcnt_d = '0;
    else if (tick)          pcnt_d = at_last ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/wt_core.sv
module wt_core #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            clr,
  input  wt_pkg::wt_ctl_t ctl,
  input  logic [DW-1:0]   load_q,
  input  logic            cap_req,
  input  logic            irq_en,
  output logic [DW-1:0]   cnt_q,
  output logic            irq_q,
  output logic [DW-1:0]   cap_q
);
  localparam logic [DW-1:0] CMAX = '1;

  logic [DW-1:0] cnt_d, cap_d;
  logic          irq_d, wrap, cap_en;

  always_comb begin
    wrap   = step && (ctl.up ? (cnt_q == CMAX) : (cnt_q == '0));
    cap_en = cap_req && irq_en;
    cnt_d  = cnt_q;
    if (clr) cnt_d = load_q;
    else if (wrap) cnt_d = ctl.periodic ? load_q : (ctl.up ? '0 : CMAX);
    else if (step) cnt_d = ctl.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    irq_d = clr ? 1'b0 : (wrap ? 1'b1 : irq_q);
    cap_d = cap_en ? cnt_q : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      cap_q <= cap_d;
    end
  end

  p_clear_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == $past(load_q)) && !irq_q);
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));
  p_down_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !ctl.up && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(step));
  p_capture_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_req && irq_en) |=> $stable(cap_q));
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int DW   = 32,
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            irq_en,
  input  logic            cap_req,
  output logic [DW-1:0]   cap_val,
  output logic            irq,
  output logic [1:0]      fmt_sel
);
  wt_pkg::wt_ctl_t ctl;
  logic [DW-1:0]   load_q, cnt;
  logic            clr, step;

  wt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .load_q(load_q), .ctl_q(ctl), .clr(clr), .rdata(rdata));

  wt_prescale #(.NSRC(NSRC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .ctl(ctl), .clr(clr),
    .step(step));

  wt_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr), .ctl(ctl),
    .load_q(load_q), .cap_req(cap_req), .irq_en(irq_en), .cnt_q(cnt),
    .irq_q(irq), .cap_q(cap_val));

  assign fmt_sel = ctl.fmt;
endmodule

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_src = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_en = 1'b0;
  logic        cap_req = 1'b0;
  logic [31:0] cap_val;
  logic        irq;
  logic [1:0]  fmt_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R9";
  bit ticks_all = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  logic [31:0] m_load = '0, m_cnt = '0, m_cap = '0;
  logic [10:0] m_ctl = '0;
  int          m_pc = 0;
  logic        m_irq = 1'b0;

  wake_timer dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_src <= ticks_all ? 4'hF : lfsr[3:0];
    cap_req  <= lfsr[5];
    irq_en   <= lfsr[9];
  end

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    int last, nxt_pc;
    bit tk, stp, clr, wrp;
    logic [31:0] nxt_cnt;
    if (!rst_n) begin
      m_load = '0; m_cnt = '0; m_cap = '0; m_ctl = '0; m_pc = 0; m_irq = 1'b0;
    end else begin
      case (m_ctl[3:0])
        4'b0100: last = 15;
        4'b1000: last = 255;
        4'b1111: last = 32767;
        default: last = 0;
      endcase
      tk  = tick_src[m_ctl[10:9]];
      clr = wr_en && addr == 2'd2;
      stp = m_ctl[7] && tk && (m_pc >= last);
      if (clr || !m_ctl[7]) nxt_pc = 0;
      else if (tk)          nxt_pc = (m_pc >= last) ? 0 : m_pc + 1;
      else                  nxt_pc = m_pc;
      wrp = stp && (m_ctl[6] ? (m_cnt == 32'hFFFF_FFFF) : (m_cnt == 0));
      nxt_cnt = m_cnt;
      if (clr) nxt_cnt = m_load;
      else if (wrp) nxt_cnt = m_ctl[8] ? m_load : (m_ctl[6] ? 32'h0 : 32'hFFFF_FFFF);
      else if (stp) nxt_cnt = m_ctl[6] ? m_cnt + 1 : m_cnt - 1;
      if (cap_req && irq_en) m_cap = m_cnt;
      if (clr) m_irq = 1'b0;
      else if (wrp) m_irq = 1'b1;
      m_cnt = nxt_cnt;
      m_pc  = nxt_pc;
      if (wr_en && addr == 2'd0) m_load = wdata;
      if (wr_en && addr == 2'd3) m_ctl = wdata[10:0];
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    #1;
    if (rst_n) begin
      case (addr)
        2'd0: exp_rd = m_load;
        2'd1: exp_rd = m_cnt;
        2'd3: exp_rd = {21'd0, m_ctl};
        default: exp_rd = '0;
      endcase
      chk(rdata === exp_rd, cur_req, rdata, exp_rd);
      chk(irq === m_irq, "R7", {31'd0, irq}, {31'd0, m_irq});
      chk(cap_val === m_cap, "R8", cap_val, m_cap);
      chk(fmt_sel === m_ctl[5:4], "R9", {30'd0, fmt_sel}, {30'd0, m_ctl[5:4]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    run(3);
    rst_n = 1'b1;
    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R9", v, 0);
    end
    chk(irq == 1'b0, "R7", {31'd0, irq}, 0);
    // R9 control masking and read-only count
    wr(2'd3, 32'hFFFF_F8FF);
    rd(2'd3, v);
    chk(v == 32'h0000_00FF, "R9", v, 32'h0000_00FF);
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h5555_5555);
    rd(2'd1, v);
    chk(v == 32'h0, "R9", v, 0);
    // R6 clear reloads
    cur_req = "R6";
    wr(2'd0, 32'h0000_1234);
    wr(2'd2, 32'hDEAD);
    rd(2'd1, v);
    chk(v == 32'h1234, "R6", v, 32'h1234);
    // R1/R5 down, free running, with wrap
    cur_req = "R5";
    ticks_all = 1'b1;
    wr(2'd0, 32'd3);
    wr(2'd3, 32'h280);
    wr(2'd2, 0);
    run(20);
    wr(2'd3, 32'h000);
    run(30);
    chk(irq == 1'b1, "R7", {31'd0, irq}, 1);
    wr(2'd2, 0);
    chk(irq == 1'b0, "R6", {31'd0, irq}, 0);
    // R5 periodic down
    wr(2'd0, 32'd4);
    wr(2'd3, 32'h380);
    wr(2'd2, 0);
    run(30);
    // R1 up periodic and free running
    cur_req = "R1";
    wr(2'd0, 32'hFFFF_FFF0);
    wr(2'd3, 32'h3C0);
    wr(2'd2, 0);
    run(40);
    wr(2'd3, 32'h2D0);
    run(40);
    // R2 prescale ratios under random ticks
    cur_req = "R2";
    ticks_all = 1'b0;
    wr(2'd3, 32'h284);
    run(2000);
    wr(2'd3, 32'h2A8);
    run(5000);
    wr(2'd3, 32'h283);
    run(200);
    ticks_all = 1'b1;
    wr(2'd0, 32'd1);
    wr(2'd3, 32'h38F);
    wr(2'd2, 0);
    run(70000);
    // R3 source selection
    cur_req = "R3";
    ticks_all = 1'b0;
    wr(2'd3, 32'h084);
    run(1000);
    wr(2'd3, 32'h4C4);
    run(1000);
    wr(2'd3, 32'h684);
    run(1000);
    wr(2'd2, 0);
    run(500);
    // R4 disable holds the count
    cur_req = "R4";
    wr(2'd3, 32'h204);
    rd(2'd1, v);
    run(60);
    rd(2'd1, v2);
    chk(v == v2, "R4", v2, v);
    wr(2'd3, 32'h280);
    run(300);
    // R8 capture against the live count
    cur_req = "R8";
    ticks_all = 1'b1;
    run(300);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule